// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block holds the interrupt event state of a network controller and drives thirteen separate interrupt request lines from it. The transmit and receive engines raise single-cycle pulses. Each pulse sets a sticky bit in a 32-bit event word, and the bit stays set until software clears it. A mask word chooses which events may reach the interrupt lines. Each line is the registered AND of one event bit and its mask bit. Lines are assigned to events through a fixed table that does not follow bit order.

Software reaches the block through a write-only register port with a 10-bit address. The port reaches five registers: event, mask, control, transmit control, and receive arm. The control register can clear all event and mask state in one write. It also holds the enable bit, which gates a receive-active status flag. A write to the transmit control register can request a graceful stop, which the block acknowledges at once by setting the GRA event.

Top module: `fec_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all `irq_o` lines and `rx_active_o` are 0.
- R2: Event bits sit in the data word at HB=31, BABR=30, BABT=29, GRA=28, TXF=27, TXB=26, RXF=25, RXB=24, MII=23, EB=22, LC=21, RL=20 and UN=19. `evt_set_i[k]` sets event bit 19+k. A write to address 0x004 clears each event bit that is 1 in the data and leaves the others unchanged.
- R3: A write to address 0x008 replaces the mask (data bits 31..19, same positions as the events). A line is active only when both its event bit and its mask bit are 1.
- R4: `irq_o[0]` through `irq_o[12]` show, in this order, TXF, TXB, UN, RL, RXF, RXB, MII, LC, HB, GRA, EB, BABT and BABR.
- R5: A write to address 0x0C4 with data bit 0 set sets GRA in the same cycle. With bit 0 clear, the write has no effect on the events.
- R6: A write to address 0x024 with data bit 0 set clears every event bit and every mask bit. It overrides event pulses that arrive in the same cycle.
- R7: When an event pulse and a software clear of the same bit arrive in the same cycle, the bit stays set.
- R8: `irq_o` is registered. A line changes on the clock edge after the edge that updates its event or mask bit.
- R9: A write to 0x010 sets `rx_active_o` only while the control enable (data bit 1 of the last 0x024 write, with bit 0 clear) is 1. Any write to 0x024 that leaves enable at 0 clears `rx_active_o`.
- R10: Event bits stay set while they are masked. Unmasking a pending event later raises its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | 10 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| evt_set_i | input | 13 | Event set pulses, index k sets bit 19+k |
| irq_o | output | 13 | Per-event interrupt request lines |
| rx_active_o | output | 1 | Receive-active status |

## Verification
The bench sets each event on its own and checks that exactly one line rises, and that it is the line the table assigns. A wrong entry in the mapping table would therefore show as the wrong single line two edges after the pulse. Corrupted sticky or mask state appears one edge after the register update, when a pending event fails to rise on unmask or a cleared event stays high. Same-cycle collisions between a pulse and a clear, and between a pulse and a control reset, are forced so that a wrong priority shows as a line that is set or missing on the next check.

// File: rtl/fec_irq_pkg.sv
`timescale 1ns/1ps
package fec_irq_pkg;
  localparam int NUM_IRQ = 13;
  localparam int EVT_LSB = 19;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;

  localparam int BIT_HB   = 31;
  localparam int BIT_BABR = 30;
  localparam int BIT_BABT = 29;
  localparam int BIT_GRA  = 28;
  localparam int BIT_TXF  = 27;
  localparam int BIT_TXB  = 26;
  localparam int BIT_RXF  = 25;
  localparam int BIT_RXB  = 24;
  localparam int BIT_MII  = 23;
  localparam int BIT_EB   = 22;
  localparam int BIT_LC   = 21;
  localparam int BIT_RL   = 20;
  localparam int BIT_UN   = 19;

  localparam logic [9:0] ADR_EVT   = 10'h004;
  localparam logic [9:0] ADR_MASK  = 10'h008;
  localparam logic [9:0] ADR_RXARM = 10'h010;
  localparam logic [9:0] ADR_CTRL  = 10'h024;
  localparam logic [9:0] ADR_TXCTL = 10'h0C4;

  // event word bit feeding a given irq line
  function automatic int irq_src_bit(input int line);
    case (line)
      0:  return BIT_TXF;
      1:  return BIT_TXB;
      2:  return BIT_UN;
      3:  return BIT_RL;
      4:  return BIT_RXF;
      5:  return BIT_RXB;
      6:  return BIT_MII;
      7:  return BIT_LC;
      8:  return BIT_HB;
      9:  return BIT_GRA;
      10: return BIT_EB;
      11: return BIT_BABT;
      default: return BIT_BABR;
    endcase
  endfunction
endpackage

// File: rtl/fec_irq_regs.sv
`timescale 1ns/1ps
module fec_irq_regs
  import fec_irq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W,
  parameter int NUM_EVT   = NUM_IRQ,
  parameter int EVT_BASE  = EVT_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_BITS-1:0] bus_addr_i,
  input  logic [DATA_BITS-1:0] bus_wdata_i,
  input  logic [NUM_EVT-1:0]   evt_set_i,
  output logic [NUM_EVT-1:0]   evt_o,
  output logic [NUM_EVT-1:0]   mask_o,
  output logic                 rx_active_o
);
  localparam int GRA_IDX = BIT_GRA - EVT_BASE;

  logic [NUM_EVT-1:0] evt_q, evt_d, mask_q, set_vec, wr_field;
  logic wr, wr_evt, wr_mask, wr_ctrl, wr_tx, wr_arm, ctl_rst, ctl_en_nxt;
  logic en_q, rx_q;

  assign wr       = bus_valid_i && bus_write_i;
  assign wr_evt   = wr && (bus_addr_i == ADDR_BITS'(ADR_EVT));
  assign wr_mask  = wr && (bus_addr_i == ADDR_BITS'(ADR_MASK));
  assign wr_ctrl  = wr && (bus_addr_i == ADDR_BITS'(ADR_CTRL));
  assign wr_tx    = wr && (bus_addr_i == ADDR_BITS'(ADR_TXCTL));
  assign wr_arm   = wr && (bus_addr_i == ADDR_BITS'(ADR_RXARM));
  assign wr_field = bus_wdata_i[EVT_BASE +: NUM_EVT];
  assign ctl_rst  = wr_ctrl && bus_wdata_i[0];
  assign ctl_en_nxt = bus_wdata_i[1] && !bus_wdata_i[0];

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[DATA_BITS-1:EVT_BASE+NUM_EVT],
                          bus_wdata_i[EVT_BASE-1:2]};

  always_comb begin
    set_vec = evt_set_i;
    if (wr_tx && bus_wdata_i[0]) set_vec[GRA_IDX] = 1'b1;
    evt_d = evt_q;
    if (wr_evt) evt_d = evt_d & ~wr_field;
    evt_d = evt_d | set_vec;  // set wins over clear
    if (ctl_rst) evt_d = '0;  // control reset wins over all
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (ctl_rst)      mask_q <= '0;
      else if (wr_mask) mask_q <= wr_field;
      if (wr_ctrl) en_q <= ctl_en_nxt;
      if (wr_ctrl && !ctl_en_nxt) rx_q <= 1'b0;
      else if (wr_arm && en_q)    rx_q <= 1'b1;
    end
  end

  assign evt_o       = evt_q;
  assign mask_o      = mask_q;
  assign rx_active_o = rx_q;

  assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && evt_set_i == '0) |=> ((evt_o & $past(wr_field)) == '0));
  assert_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_evt && !ctl_rst) |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
  assert_set_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_rst) |=> ((evt_o & $past(evt_set_i)) == $past(evt_set_i)));
  assert_gra_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && bus_wdata_i[0] && !ctl_rst) |=> evt_o[GRA_IDX]);
  assert_ctl_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst |=> (evt_o == '0 && mask_o == '0));
  assert_rx_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !ctl_en_nxt) |=> !rx_active_o);
endmodule

// File: rtl/fec_irq_fanout.sv
`timescale 1ns/1ps
module fec_irq_fanout
  import fec_irq_pkg::*;
#(
  parameter int NUM_LINES = NUM_IRQ,
  parameter int EVT_BASE  = EVT_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic [NUM_LINES-1:0] irq_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam int SRC = irq_src_bit(g) - EVT_BASE;
    logic line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q <= 1'b0;
      else         line_q <= evt_i[SRC] && mask_i[SRC];
    end
    assign irq_o[g] = line_q;

    assert_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> ($past(mask_i[SRC]) && $past(evt_i[SRC])));
  end
endmodule

// File: rtl/fec_irq_ctrl.sv
`timescale 1ns/1ps
module fec_irq_ctrl
  import fec_irq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W,
  parameter int NUM_LINES = NUM_IRQ
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_BITS-1:0] bus_addr_i,
  input  logic [DATA_BITS-1:0] bus_wdata_i,
  input  logic [NUM_LINES-1:0] evt_set_i,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 rx_active_o
);
  logic [NUM_LINES-1:0] evt_w, mask_w;

  fec_irq_regs #(
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS),
    .NUM_EVT(NUM_LINES), .EVT_BASE(EVT_LSB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .evt_set_i(evt_set_i),
    .evt_o(evt_w), .mask_o(mask_w), .rx_active_o(rx_active_o)
  );

  fec_irq_fanout #(.NUM_LINES(NUM_LINES), .EVT_BASE(EVT_LSB)) u_fanout (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_i(evt_w), .mask_i(mask_w), .irq_o(irq_o)
  );

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (irq_o == '0 && !rx_active_o));
endmodule

// File: tb/tb_fec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_fec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [12:0] evt_set = '0;
  logic [12:0] irq;
  logic        rx_act;
  int checks = 0, fails = 0;
  bit done = 0;

  // line order: TXF TXB UN RL RXF RXB MII LC HB GRA EB BABT BABR
  localparam int LINE_BIT [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #10ns clk = ~clk;

  fec_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .evt_set_i(evt_set),
    .irq_o(irq), .rx_active_o(rx_act)
  );

  function automatic logic [12:0] exp_irq(input logic [31:0] ev, input logic [31:0] mk);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = ev[LINE_BIT[i]] & mk[LINE_BIT[i]];
    return r;
  endfunction

  function automatic logic [12:0] pulse_of(input int b);
    return 13'(1) << (b - 19);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; wr = 0;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic t_reset;
    chk(irq, 0, "R1 irq in reset");
    chk(rx_act, 0, "R1 rx in reset");
    @(negedge clk); rst_n = 1;
    settle();
    chk(irq, 0, "R1 irq after reset");
    chk(rx_act, 0, "R1 rx after reset");
  endtask

  task automatic t_mapping;
    bus_wr(10'h008, 32'hFFF8_0000);
    for (int i = 0; i < 13; i++) begin
      pulse(pulse_of(LINE_BIT[i]));
      settle();
      chk(irq, 13'(1) << i, $sformatf("R4 line %0d", i));
      bus_wr(10'h004, 32'h1 << LINE_BIT[i]);
      settle();
      chk(irq, 0, $sformatf("R2 clear line %0d", i));
    end
  endtask

  task automatic t_latency;
    pulse(pulse_of(25));
    chk(irq, 0, "R8 not yet");
    settle();
    chk(irq, exp_irq(32'h1 << 25, 32'hFFF8_0000), "R8 one edge later");
    bus_wr(10'h004, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_mask_sticky;
    bus_wr(10'h008, 32'h0);
    pulse(pulse_of(27) | pulse_of(24));
    settle();
    chk(irq, 0, "R3 masked");
    bus_wr(10'h008, 32'h1 << 24);
    settle();
    chk(irq, exp_irq((32'h1 << 27) | (32'h1 << 24), 32'h1 << 24), "R10 pending shows on unmask");
    bus_wr(10'h008, 32'hFFF8_0000);
    settle();
    chk(irq, exp_irq((32'h1 << 27) | (32'h1 << 24), 32'hFFF8_0000), "R3 mask replaced");
    bus_wr(10'h004, 32'h1 << 27);
    settle();
    chk(irq, exp_irq(32'h1 << 24, 32'hFFF8_0000), "R2 partial clear");
    bus_wr(10'h004, 32'h1 << 24);
    settle();
    chk(irq, 0, "R2 all clear");
  endtask

  task automatic t_set_prio;
    @(negedge clk);
    evt_set = pulse_of(26); valid = 1; wr = 1; addr = 10'h004; wdata = 32'h1 << 26;
    @(negedge clk);
    evt_set = '0; valid = 0; wr = 0;
    settle();
    chk(irq, exp_irq(32'h1 << 26, 32'hFFF8_0000), "R7 set beats clear");
    bus_wr(10'h004, 32'h1 << 26);
    settle();
  endtask

  task automatic t_gra;
    bus_wr(10'h0C4, 32'h2);
    settle();
    chk(irq, 0, "R5 bit0 clear no effect");
    bus_wr(10'h0C4, 32'h1);
    settle();
    chk(irq, exp_irq(32'h1 << 28, 32'hFFF8_0000), "R5 GRA set");
    bus_wr(10'h004, 32'h1 << 28);
    settle();
  endtask

  task automatic t_ctrl_reset;
    pulse(pulse_of(31) | pulse_of(19));
    settle();
    chk(irq, exp_irq((32'h1 << 31) | (32'h1 << 19), 32'hFFF8_0000), "R6 setup");
    @(negedge clk);
    evt_set = pulse_of(22); valid = 1; wr = 1; addr = 10'h024; wdata = 32'h1;
    @(negedge clk);
    evt_set = '0; valid = 0; wr = 0;
    settle();
    chk(irq, 0, "R6 cleared");
    bus_wr(10'h008, 32'hFFF8_0000);
    settle();
    chk(irq, 0, "R6 events stayed clear");
    bus_wr(10'h008, 32'h0);
    pulse(pulse_of(21));
    settle();
    chk(irq, 0, "R6 mask was cleared");
    bus_wr(10'h004, 32'hFFFF_FFFF);
  endtask

  task automatic t_rx;
    bus_wr(10'h010, 32'h0);
    chk(rx_act, 0, "R9 arm while disabled");
    bus_wr(10'h024, 32'h2);
    bus_wr(10'h010, 32'h0);
    chk(rx_act, 1, "R9 arm while enabled");
    bus_wr(10'h024, 32'h0);
    chk(rx_act, 0, "R9 disable drops rx");
    bus_wr(10'h024, 32'h2);
    bus_wr(10'h010, 32'h0);
    bus_wr(10'h024, 32'h3);
    chk(rx_act, 0, "R9 reset write drops rx");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mapping();
    t_latency();
    t_mask_sticky();
    t_set_prio();
    t_gra();
    t_ctrl_reset();
    t_rx();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule